// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Output Compare

This block is a free-running up-counter that serves as the shared time base for two banks of channels. The counter advances on a one-cycle enable pulse from a power-of-two prescaler, so all logic runs in one clock domain. It can restart from zero when it matches compare channel 0. When it wraps from all ones to zero it raises an overflow flag.

Each input-capture channel synchronises its external pin and watches it for a rising edge, a falling edge, or either edge, as configured. On a qualifying edge the channel stores the current count and raises its flag. Each output-compare channel raises its flag when the counter advances while equal to the channel's compare register. Compare channels are grouped in pairs. In single mode each channel toggles its own pin. In paired mode the even channel sets the pair's even pin, the odd channel clears it, and the odd pin is held low.

A write-only register port sets up the block. A separate set of clear inputs acknowledges flags.

Top module: `frt_capcmp_top`

## Requirements
- R1: After reset the count, every flag, every captured value and every compare pin are zero. The count stays at zero until the run bit (bit 0 of the control register at address 0) is written as 1.
- R2: Control bits [3:1] select a divider of 2^sel, with sel from 0 to 7. Counting from the clock edge that writes the run bit, the count after n further clock edges equals floor(n / 2^sel).
- R3: When the counter advances from all ones to zero, the overflow flag becomes 1 on that same edge.
- R4: When control bit 4 (clear-on-match) is 1, an advance taken while the count equals compare register 0 loads zero instead of count+1. The count then repeats with a period of compare-value + 1 advances.
- R5: Address 1 holds 2 bits per capture channel, at bits [2i+1:2i]: 00 none, 01 rising, 10 falling, 11 both. An edge that the channel's setting does not select leaves the channel's value and flag unchanged.
- R6: A pin transition first seen at clock edge k is captured at edge k+2. The stored value is the count in the cycle before edge k+2, and the channel's flag is set on that edge.
- R7: Compare register i sits at address 4+i. Its flag is set on a counter advance taken while the count equals the register.
- R8: In single mode (pair-enable bit 0) each compare match toggles that channel's pin.
- R9: Address 2 bit p enables pair p, made of channels 2p and 2p+1. In paired mode a match on 2p drives pin 2p high, and a match on 2p+1 drives it low. The set wins if both match together, and pin 2p+1 is held low.
- R10: Every flag stays at 1 until its clear input is high at a clock edge. A new event on the same edge as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| cap_clr | input | N_CAP | Per-channel capture flag clear |
| cmp_clr | input | N_CMP | Per-channel compare flag clear |
| cap_pin | input | N_CAP | External capture inputs |
| count | output | CNT_W | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| cap_flag | output | N_CAP | Capture flags |
| cap_val | output | N_CAP*CNT_W | Captured values, channel i at bits [i*CNT_W +: CNT_W] |
| cmp_flag | output | N_CMP | Compare flags |
| cmp_out | output | N_CMP | Compare output pins |

## Verification
The bench builds the block with an 8-bit counter, three capture channels and four compare channels. The narrow counter puts the all-ones-to-zero wrap, and a full toggle period of a single-mode pin, within a few hundred cycles. Three capture channels give one channel for each edge setting at the same time. Four compare channels make two pairs, so one pair can place the set and clear on different counts while the other tests a simultaneous set and clear.

// File: rtl/frt_pkg.sv
package frt_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_mode_e;

   localparam int ADDR_CTRL     = 0;
   localparam int ADDR_EDGE     = 1;
   localparam int ADDR_PAIR     = 2;
   localparam int ADDR_CMP_BASE = 4;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_SEL_LSB  = 1;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = (1 << SEL_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W:0]   mask_w;

   always_comb begin
      mask_w = ((DIV_W+1)'(1) << sel) - (DIV_W+1)'(1);
      tick   = run && ((div_q & mask_w[DIV_W-1:0]) == mask_w[DIV_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (run) div_q <= div_q + DIV_W'(1);
      else          div_q <= '0;
   end

   AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick); // R1
   AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sel == '0) |-> tick); // R2
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr_en,
   input  logic [CNT_W-1:0] cmp0,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf_flag
);
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             restart;
   logic             wrap;

   always_comb begin
      restart = tick && clr_en && (cnt_q == cmp0);
      wrap    = tick && !restart && (cnt_q == {CNT_W{1'b1}});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (restart)   cnt_q <= '0;
         else if (tick) cnt_q <= cnt_q + CNT_W'(1);
         ovf_q <= wrap | (ovf_q & ~ovf_clr);
      end
   end

   assign cnt      = cnt_q;
   assign ovf_flag = ovf_q;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q)); // R2
   AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clr_en && cnt_q == cmp0) |=> (cnt_q == '0)); // R4
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(clr_en && cnt_q == cmp0) && cnt_q == {CNT_W{1'b1}}) |=> (ovf_q && cnt_q == '0)); // R3
endmodule

// File: rtl/frt_capture_ch.sv
module frt_capture_ch
   import frt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic             clr,
   output logic [CNT_W-1:0] val,
   output logic             flag
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   prev_q;
   logic                   hit;
   logic [CNT_W-1:0]       val_q;
   logic                   flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   always_comb begin
      unique case (edge_mode_e'(mode))
         EDGE_RISE: hit = synced & ~prev_q;
         EDGE_FALL: hit = ~synced & prev_q;
         EDGE_ANY:  hit = synced ^ prev_q;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         val_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= synced;
         if (hit) val_q <= cnt;
         flag_q <= hit | (flag_q & ~clr);
      end
   end

   assign val  = val_q;
   assign flag = flag_q;

   AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (val_q == $past(cnt) && flag_q)); // R6
   AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q); // R10
   AST_CAP_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> $stable(val_q)); // R5
endmodule

// File: rtl/frt_compare_bank.sv
module frt_compare_bank #(
   parameter int CNT_W = 16,
   parameter int N_CMP = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic [CNT_W-1:0]        cnt,
   input  logic [N_CMP*CNT_W-1:0]  cmp_vals,
   input  logic [N_CMP/2-1:0]      pair_en,
   input  logic [N_CMP-1:0]        clr,
   output logic [N_CMP-1:0]        flag,
   output logic [N_CMP-1:0]        out
);
   localparam int N_PAIR = N_CMP / 2;

   logic [N_CMP-1:0] hit;
   logic [N_CMP-1:0] flag_q;

   always_comb begin
      for (int i = 0; i < N_CMP; i++)
         hit[i] = tick && (cnt == cmp_vals[i*CNT_W +: CNT_W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= hit | (flag_q & ~clr);
   end

   assign flag = flag_q;

   for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
      logic ev_q;
      logic od_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ev_q <= 1'b0;
            od_q <= 1'b0;
         end else if (pair_en[p]) begin
            if (hit[2*p])        ev_q <= 1'b1;
            else if (hit[2*p+1]) ev_q <= 1'b0;
            od_q <= 1'b0;
         end else begin
            ev_q <= ev_q ^ hit[2*p];
            od_q <= od_q ^ hit[2*p+1];
         end
      end

      assign out[2*p]   = ev_q;
      assign out[2*p+1] = od_q;

      AST_PAIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (pair_en[p] && hit[2*p]) |=> ev_q); // R9
      AST_PAIR_ODD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         pair_en[p] |=> !od_q); // R9
      AST_SINGLE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
         (!pair_en[p] && hit[2*p+1]) |=> (od_q != $past(od_q))); // R8
   end

   AST_CMP_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit))); // R7
endmodule

// File: rtl/frt_capcmp_top.sv
module frt_capcmp_top
   import frt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SEL_W       = 3,
   parameter int N_CAP       = 6,
   parameter int N_CMP       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   ovf_clr,
   input  logic [N_CAP-1:0]       cap_clr,
   input  logic [N_CMP-1:0]       cmp_clr,
   input  logic [N_CAP-1:0]       cap_pin,
   output logic [CNT_W-1:0]       count,
   output logic                   ovf_flag,
   output logic [N_CAP-1:0]       cap_flag,
   output logic [N_CAP*CNT_W-1:0] cap_val,
   output logic [N_CMP-1:0]       cmp_flag,
   output logic [N_CMP-1:0]       cmp_out
);
   localparam int N_PAIR    = N_CMP / 2;
   localparam int EDGE_W    = 2 * N_CAP;
   localparam int CLRM_BIT  = CTRL_SEL_LSB + SEL_W;

   if (N_CMP < 2 || (N_CMP % 2) != 0) begin : g_bad_cmp
      $error("N_CMP must be an even number of at least 2");
   end
   if (EDGE_W > DATA_W || N_PAIR > DATA_W || CNT_W > DATA_W || CLRM_BIT >= DATA_W) begin : g_bad_width
      $error("a register field does not fit in DATA_W");
   end
   if (ADDR_CMP_BASE + N_CMP > (1 << ADDR_W)) begin : g_bad_addr
      $error("compare registers exceed the address space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                   run_q;
   logic [SEL_W-1:0]       sel_q;
   logic                   clrm_q;
   logic [EDGE_W-1:0]      edge_q;
   logic [N_PAIR-1:0]      pair_q;
   logic [N_CMP*CNT_W-1:0] cmp_q;
   logic                   tick;
   logic [CNT_W-1:0]       cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sel_q  <= '0;
         clrm_q <= 1'b0;
         edge_q <= '0;
         pair_q <= '0;
         cmp_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
            run_q  <= wr_data[CTRL_RUN_BIT];
            sel_q  <= wr_data[CTRL_SEL_LSB +: SEL_W];
            clrm_q <= wr_data[CLRM_BIT];
         end
         if (wr_addr == ADDR_W'(ADDR_EDGE)) edge_q <= wr_data[EDGE_W-1:0];
         if (wr_addr == ADDR_W'(ADDR_PAIR)) pair_q <= wr_data[N_PAIR-1:0];
         for (int i = 0; i < N_CMP; i++) begin
            if (wr_addr == ADDR_W'(ADDR_CMP_BASE + i))
               cmp_q[i*CNT_W +: CNT_W] <= wr_data[CNT_W-1:0];
         end
      end
   end

   frt_prescaler #(.SEL_W(SEL_W)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run_q),
      .sel  (sel_q),
      .tick (tick)
   );

   frt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .clr_en  (clrm_q),
      .cmp0    (cmp_q[CNT_W-1:0]),
      .ovf_clr (ovf_clr),
      .cnt     (cnt),
      .ovf_flag(ovf_flag)
   );

   for (genvar c = 0; c < N_CAP; c++) begin : g_cap
      frt_capture_ch #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (cap_pin[c]),
         .mode (edge_q[2*c +: 2]),
         .cnt  (cnt),
         .clr  (cap_clr[c]),
         .val  (cap_val[c*CNT_W +: CNT_W]),
         .flag (cap_flag[c])
      );
   end

   frt_compare_bank #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cnt     (cnt),
      .cmp_vals(cmp_q),
      .pair_en (pair_q),
      .clr     (cmp_clr),
      .flag    (cmp_flag),
      .out     (cmp_out)
   );

   assign count = cnt;

   AST_HELD_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && count == '0) |=> (count == '0)); // R1
endmodule

// File: tb/frt_capcmp_top_tb.sv
module frt_capcmp_top_tb;
   localparam int CNT_W  = 8;
   localparam int N_CAP  = 3;
   localparam int N_CMP  = 4;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 16;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   wr_en = 1'b0;
   logic [ADDR_W-1:0]      wr_addr = '0;
   logic [DATA_W-1:0]      wr_data = '0;
   logic                   ovf_clr = 1'b0;
   logic [N_CAP-1:0]       cap_clr = '0;
   logic [N_CMP-1:0]       cmp_clr = '0;
   logic [N_CAP-1:0]       cap_pin = '0;
   logic [CNT_W-1:0]       count;
   logic                   ovf_flag;
   logic [N_CAP-1:0]       cap_flag;
   logic [N_CAP*CNT_W-1:0] cap_val;
   logic [N_CMP-1:0]       cmp_flag;
   logic [N_CMP-1:0]       cmp_out;

   int n_run  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   frt_capcmp_top #(
      .CNT_W(CNT_W), .SEL_W(3), .N_CAP(N_CAP), .N_CMP(N_CMP),
      .SYNC_STAGES(2), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ovf_clr(ovf_clr), .cap_clr(cap_clr), .cmp_clr(cmp_clr), .cap_pin(cap_pin),
      .count(count), .ovf_flag(ovf_flag), .cap_flag(cap_flag), .cap_val(cap_val),
      .cmp_flag(cmp_flag), .cmp_out(cmp_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cap_pin = '0; cmp_clr = '0; cap_clr = '0; ovf_clr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int cv(input int ch);
      return int'(cap_val[ch*CNT_W +: CNT_W]);
   endfunction

   task automatic t_reset();
      do_reset();
      chk("R1 count", int'(count), 0);
      chk("R1 flags", int'({ovf_flag, cap_flag, cmp_flag}), 0);
      chk("R1 pins/values", int'({cmp_out, cap_val}), 0);
      wait_n(6);
      chk("R1 held before run", int'(count), 0);
   endtask

   task automatic t_prescale(input int sel);
      do_reset();
      wr(0, 1 | (sel << 1));
      wait_n(63);
      chk("R2 count at 63", int'(count), 63 >> sel);
      wait_n(1);
      chk("R2 count at 64", int'(count), 64 >> sel);
   endtask

   task automatic t_overflow();
      do_reset();
      wr(0, 1);
      wait_n(255);
      chk("R3 before wrap", int'({ovf_flag, count}), 255);
      wait_n(1);
      chk("R3 wrap sets flag", int'({ovf_flag, count}), 256);
      wait_n(5);
      chk("R10 ovf sticky", int'(ovf_flag), 1);
      ovf_clr = 1'b1; wait_n(1); ovf_clr = 1'b0;
      chk("R10 ovf cleared", int'(ovf_flag), 0);
   endtask

   task automatic t_clear_match();
      do_reset();
      wr(4, 9);
      cmp_clr[0] = 1'b1;
      wr(0, 1 | (1 << 4));
      wait_n(9);
      chk("R4 count at match value", int'(count), 9);
      chk("R7 no flag before advance", int'(cmp_flag[0]), 0);
      wait_n(1);
      chk("R4 restart to zero", int'(count), 0);
      chk("R10 event beats clear", int'(cmp_flag[0]), 1);
      wait_n(1);
      chk("R10 clear without event", int'(cmp_flag[0]), 0);
      cmp_clr[0] = 1'b0;
      wait_n(9);
      chk("R4 period of ten", int'(count), 0);
   endtask

   task automatic t_single();
      do_reset();
      wr(5, 5);
      wr(0, 1);
      wait_n(5);
      chk("R7 ch1 before match", int'({cmp_flag[1], cmp_out[1]}), 0);
      wait_n(1);
      chk("R7 ch1 flag", int'(cmp_flag[1]), 1);
      chk("R8 ch1 toggles high", int'(cmp_out[1]), 1);
      wait_n(4);
      chk("R10 ch1 flag sticky", int'(cmp_flag[1]), 1);
      wait_n(252);
      chk("R8 ch1 toggles back", int'(cmp_out[1]), 0);
   endtask

   task automatic t_paired();
      do_reset();
      wr(4, 3); wr(5, 7); wr(6, 4); wr(7, 4);
      wr(2, 3);
      wr(0, 1);
      wait_n(3);
      chk("R9 pair0 low before set", int'(cmp_out[0]), 0);
      wait_n(1);
      chk("R9 pair0 set", int'(cmp_out[1:0]), 1);
      wait_n(1);
      chk("R9 set wins on tie", int'(cmp_out[3:2]), 1);
      chk("R7 both tie flags", int'(cmp_flag[3:2]), 3);
      wait_n(3);
      chk("R9 pair0 cleared", int'(cmp_out[1:0]), 0);
   endtask

   task automatic t_capture();
      do_reset();
      wr(1, 6'b111001);
      wr(0, 1);
      wait_n(10);
      cap_pin = 3'b111;
      wait_n(2);
      chk("R6 latency", int'(cap_flag), 0);
      wait_n(1);
      chk("R5 rising selects ch0 ch2", int'(cap_flag), 3'b101);
      chk("R6 ch0 value", cv(0), 12);
      chk("R6 ch2 value", cv(2), 12);
      cap_clr = '1; wait_n(1); cap_clr = '0;
      chk("R10 capture flags cleared", int'(cap_flag), 0);
      cap_pin = 3'b000;
      wait_n(3);
      chk("R5 falling selects ch1 ch2", int'(cap_flag), 3'b110);
      chk("R6 ch1 value", cv(1), 16);
      chk("R6 ch2 value both edges", cv(2), 16);
      chk("R5 ch0 ignores falling", cv(0), 12);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_prescale(0);
      t_prescale(2);
      t_prescale(5);
      t_overflow();
      t_clear_match();
      t_single();
      t_paired();
      t_capture();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule